// File: doc/BRIEF.md
# MII Transmit Frame Check Sequence Inserter

This block sits in a 4-bit transmit path for 10 and 100 Mb/s Ethernet. It watches a nibble stream qualified by a transmit-enable input. Preamble nibbles and the start-of-frame delimiter are forwarded untouched. Every nibble after the delimiter is forwarded and also folded into a running CRC-32. When the enable drops, the block appends the four-byte frame check sequence as eight further nibbles on the same stream.

The CRC advances one nibble per clock through a 16-entry lookup that is computed at elaboration from the reflected polynomial. Bytes arrive low nibble first, and the CRC consumes them in that order. Every output is registered, so the outgoing stream trails the incoming one by one clock.

Top module: `mii_fcs_inserter`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, out_en is 0 and out_nib is 0.
- R2: Every nibble presented with in_en high outside the FCS and drop phases appears on out_nib one clock later with out_en high. This includes preamble nibbles, the delimiter and payload nibbles.
- R3: The delimiter is a 0xD nibble that directly follows at least one 0x5 nibble within the same enabled burst. A 0xD that has no 0x5 immediately before it is forwarded as ordinary preamble.
- R4: The CRC is preset to 0xFFFFFFFF at the delimiter. It is updated once per payload nibble, in arrival order (low nibble of each byte first), using the reflected polynomial 0xEDB88320. The value sent is the bitwise complement of the register.
- R5: FCS nibble k (k = 0 first, up to 7) carries bits [4k+3:4k] of the complemented CRC. The CRC is therefore sent least-significant byte first, low nibble first.
- R6: When in_en falls after the delimiter, out_en stays high for exactly eight more clocks, one for each FCS nibble, and then drops.
- R7: Whenever out_en is low, out_nib is 0.
- R8: If in_en is high on the clock that carries the last FCS nibble, that burst is discarded. No output is produced until in_en has been low for at least one clock.
- R9: A frame with no payload nibbles after the delimiter gets an FCS of eight 0x0 nibbles.
- R10: For the payload bytes of the ASCII text "ABCDEFGH12345678", the transmitted FCS is 0x3EEF6489, with nibble order 9,8,4,6,F,E,E,3.
- R11: A burst that ends before any delimiter has been seen gets no FCS: out_en is low from the clock after its last forwarded nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_en | input | 1 | Transmit enable of the incoming stream |
| in_nib | input | 4 | Incoming nibble |
| out_en | output | 1 | Registered transmit enable of the outgoing stream |
| out_nib | output | 4 | Registered outgoing nibble, with the FCS appended |

## Verification
The bench builds the block with its default parameters: the reflected Ethernet polynomial, 0x5 as the preamble nibble and 0xD as the delimiter. With these values the published check value for the ASCII test string can be compared directly against the nibbles on the wire. The bench also uses these defaults to run random frames through a behavioural bit-serial CRC model. These frames vary preamble length, payload length down to zero, and the idle gap between frames. Short gaps make some new bursts land inside the FCS, so the drop behaviour is exercised alongside normal back-to-back frames.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam int CRC_W    = 32;
    localparam int NIB_W    = 4;
    localparam int FCS_NIBS = CRC_W / NIB_W;
    localparam int CNT_W    = $clog2(FCS_NIBS);
    localparam int LUT_N    = 1 << NIB_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_DATA,
        S_FCS,
        S_DROP
    } fcs_state_e;

    typedef struct packed {
        fcs_state_e             st;
        logic                   seen_pre;
        logic [CRC_W-1:0]       crc;
        logic [CNT_W-1:0]       cnt;
        logic                   oen;
        logic [NIB_W-1:0]       onib;
    } fcs_regs_t;

    // Reflected CRC of a NIB_W-bit index: one table entry.
    function automatic logic [CRC_W-1:0] lut_entry(input logic [CRC_W-1:0] poly,
                                                   input int idx);
        logic [CRC_W-1:0] c;
        c = CRC_W'(idx);
        for (int b = 0; b < NIB_W; b++) begin
            c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/fcs_crc_nibble.sv
module fcs_crc_nibble
    import fcs_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
    input  logic [CRC_W-1:0] crc_i,
    input  logic [NIB_W-1:0] nib_i,
    output logic [CRC_W-1:0] crc_o
);
    logic [CRC_W-1:0] tbl [LUT_N];
    logic [NIB_W-1:0] sel;

    for (genvar i = 0; i < LUT_N; i++) begin : g_lut
        assign tbl[i] = lut_entry(POLY, i);
    end

    assign sel   = crc_i[NIB_W-1:0] ^ nib_i;
    assign crc_o = (crc_i >> NIB_W) ^ tbl[sel];
endmodule

// File: rtl/fcs_nib_select.sv
module fcs_nib_select
    import fcs_pkg::*;
(
    input  logic [CRC_W-1:0] word_i,
    input  logic [CNT_W-1:0] idx_i,
    output logic [NIB_W-1:0] nib_o
);
    logic [NIB_W-1:0] slice [FCS_NIBS];

    for (genvar k = 0; k < FCS_NIBS; k++) begin : g_slice
        assign slice[k] = word_i[k*NIB_W +: NIB_W];
    end

    assign nib_o = slice[idx_i];
endmodule

// File: rtl/mii_fcs_inserter.sv
module mii_fcs_inserter
    import fcs_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY    = 32'hEDB88320,
    parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
    parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_en,
    input  logic [NIB_W-1:0] in_nib,
    output logic             out_en,
    output logic [NIB_W-1:0] out_nib
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FCS_NIBS - 1);

    fcs_regs_t        r_d, r_q;
    logic [CRC_W-1:0] crc_step_d;
    logic [CNT_W-1:0] fcs_idx_d;
    logic [NIB_W-1:0] fcs_nib_d;
    fcs_state_e       st_w;
    logic [CNT_W-1:0] cnt_w;
    logic             seen_w;

    fcs_crc_nibble #(.POLY(POLY)) u_crc (
        .crc_i (r_q.crc),
        .nib_i (in_nib),
        .crc_o (crc_step_d)
    );

    assign fcs_idx_d = (r_q.st == S_FCS) ? r_q.cnt : '0;

    fcs_nib_select u_sel (
        .word_i (~r_q.crc),
        .idx_i  (fcs_idx_d),
        .nib_o  (fcs_nib_d)
    );

    always_comb begin
        r_d      = r_q;
        r_d.oen  = 1'b0;
        r_d.onib = '0;
        unique case (r_q.st)
            S_IDLE: begin
                if (in_en) begin
                    r_d.st       = S_PRE;
                    r_d.oen      = 1'b1;
                    r_d.onib     = in_nib;
                    r_d.seen_pre = (in_nib == PRE_NIB);
                end
            end
            S_PRE: begin
                if (in_en) begin
                    r_d.oen  = 1'b1;
                    r_d.onib = in_nib;
                    if (in_nib == SFD_NIB && r_q.seen_pre) begin
                        r_d.st  = S_DATA;
                        r_d.crc = '1;
                    end else begin
                        r_d.seen_pre = (in_nib == PRE_NIB);
                    end
                end else begin
                    r_d.st       = S_IDLE;
                    r_d.seen_pre = 1'b0;
                end
            end
            S_DATA: begin
                r_d.oen = 1'b1;
                if (in_en) begin
                    r_d.onib = in_nib;
                    r_d.crc  = crc_step_d;
                end else begin
                    r_d.onib = fcs_nib_d;
                    r_d.cnt  = CNT_W'(1);
                    r_d.st   = S_FCS;
                end
            end
            S_FCS: begin
                r_d.oen  = 1'b1;
                r_d.onib = fcs_nib_d;
                r_d.cnt  = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST_IDX) begin
                    r_d.st = in_en ? S_DROP : S_IDLE;
                end
            end
            S_DROP: begin
                if (!in_en) begin
                    r_d.st = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= S_IDLE;
            r_q.seen_pre <= 1'b0;
            r_q.crc      <= '1;
            r_q.cnt      <= '0;
            r_q.oen      <= 1'b0;
            r_q.onib     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_en  = r_q.oen;
    assign out_nib = r_q.onib;
    assign st_w    = r_q.st;
    assign cnt_w   = r_q.cnt;
    assign seen_w  = r_q.seen_pre;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
    import fcs_pkg::*;
#(
    parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_en,
    input logic [NIB_W-1:0] in_nib,
    input logic             out_en,
    input logic [NIB_W-1:0] out_nib,
    input fcs_state_e       st,
    input logic [CNT_W-1:0] cnt,
    input logic             seen_pre
);
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> out_nib == '0);

    a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_IDLE || st == S_PRE || st == S_DATA) && in_en)
        |=> (out_en && out_nib == $past(in_nib)));

    a_r3_sfd_enters_data: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PRE && in_en && in_nib == SFD_NIB && seen_pre) |=> st == S_DATA);

    a_r6_fcs_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DATA && !in_en) |=> (out_en && st == S_FCS));

    a_r6_fcs_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FCS && cnt == CNT_W'(FCS_NIBS - 1)) |=> (out_en && st != S_FCS));

    a_r8_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DROP) |=> (!out_en || $past(!in_en)));

    a_r11_idle_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PRE && !in_en) |=> !out_en);
endmodule

bind mii_fcs_inserter fcs_checker #(.SFD_NIB(SFD_NIB)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_en    (in_en),
    .in_nib   (in_nib),
    .out_en   (out_en),
    .out_nib  (out_nib),
    .st       (st_w),
    .cnt      (cnt_w),
    .seen_pre (seen_w)
);

// File: tb/tb_mii_fcs_inserter.sv
module tb_mii_fcs_inserter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_en = 1'b0;
    logic [3:0] in_nib = 4'h0;
    logic       out_en;
    logic [3:0] out_nib;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R2";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    mii_fcs_inserter dut (
        .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_nib(in_nib),
        .out_en(out_en), .out_nib(out_nib)
    );

    // Behavioural reference: bit-serial CRC, FCS nibbles queued.
    int          mode = 0; // 0 idle, 1 preamble, 2 payload, 3 fcs, 4 discard
    bit          prev5 = 1'b0;
    logic [31:0] mcrc = 32'hFFFFFFFF;
    logic [3:0]  fq[$];
    logic        exp_en = 1'b0;
    logic [3:0]  exp_nib = 4'h0;

    function automatic logic [31:0] crc_bits(input logic [31:0] c, input logic [3:0] n);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 4; b++) begin
            if (r[0] ^ n[b]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mode = 0; prev5 = 1'b0; mcrc = 32'hFFFFFFFF; fq.delete();
            exp_en = 1'b0; exp_nib = 4'h0;
        end else begin
            exp_en = 1'b0; exp_nib = 4'h0;
            case (mode)
                0: if (in_en) begin
                    exp_en = 1'b1; exp_nib = in_nib; prev5 = (in_nib == 4'h5); mode = 1;
                end
                1: if (in_en) begin
                    exp_en = 1'b1; exp_nib = in_nib;
                    if (in_nib == 4'hD && prev5) begin mode = 2; mcrc = 32'hFFFFFFFF; end
                    else prev5 = (in_nib == 4'h5);
                end else begin
                    mode = 0; prev5 = 1'b0;
                end
                2: if (in_en) begin
                    exp_en = 1'b1; exp_nib = in_nib; mcrc = crc_bits(mcrc, in_nib);
                end else begin
                    for (int k = 0; k < 8; k++) fq.push_back(~mcrc >> (4 * k));
                    exp_en = 1'b1; exp_nib = fq.pop_front(); mode = 3;
                end
                3: begin
                    exp_en = 1'b1; exp_nib = fq.pop_front();
                    if (fq.size() == 0) mode = in_en ? 4 : 0;
                end
                default: if (!in_en) mode = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (out_en !== exp_en || out_nib !== exp_nib) begin
                miscompares++;
                $display("FAIL %s: out_en/out_nib = %0b/%h, expected %0b/%h",
                         cur_req, out_en, out_nib, exp_en, exp_nib);
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h, expected %h", req, act, expv);
        end
    endtask

    task automatic drive(input logic e, input logic [3:0] n);
        @(negedge clk);
        in_en = e; in_nib = n;
    endtask

    task automatic preamble(input int n5);
        for (int i = 0; i < n5; i++) drive(1'b1, 4'h5);
        drive(1'b1, 4'hD);
    endtask

    task automatic send_byte(input logic [7:0] b);
        drive(1'b1, b[3:0]);
        drive(1'b1, b[7:4]);
    endtask

    // Call right after in_en was driven low: checks the eight FCS nibbles.
    task automatic expect_fcs(input logic [31:0] f, input string req);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); #1;
            check(out_en === 1'b1 && out_nib === f[4*k +: 4], req,
                  {3'b0, out_en, out_nib}, {4'h1, f[4*k +: 4]});
        end
        @(negedge clk); #1;
        check(out_en === 1'b0, req, {7'b0, out_en}, 8'h00);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 4'h0);
    endtask

    initial begin
        string txt;
        txt = "ABCDEFGH12345678";

        // R1: reset state
        repeat (2) @(negedge clk);
        #1 check(out_en === 1'b0 && out_nib === 4'h0, "R1", {3'b0, out_en, out_nib}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(out_en === 1'b0 && out_nib === 4'h0, "R1", {3'b0, out_en, out_nib}, 8'h00);

        // R10 / R4 / R5: known ASCII vector
        cur_req = "R10";
        preamble(7);
        for (int i = 0; i < txt.len(); i++) send_byte(txt[i]);
        drive(1'b0, 4'h0);
        expect_fcs(32'h3EEF6489, "R10");
        idle(3);

        // R9: empty payload
        cur_req = "R9";
        preamble(3);
        drive(1'b0, 4'h0);
        expect_fcs(32'h00000000, "R9");
        idle(2);

        // R11 / R3: burst with no delimiter
        cur_req = "R11";
        drive(1'b1, 4'h5); drive(1'b1, 4'h5); drive(1'b1, 4'h3); drive(1'b1, 4'hD);
        drive(1'b0, 4'h0);
        @(negedge clk); #1;
        check(out_en === 1'b0, "R11", {7'b0, out_en}, 8'h00);
        idle(4);

        // R3: 0xD without preceding 0x5 is not a delimiter
        cur_req = "R3";
        drive(1'b1, 4'hD); drive(1'b1, 4'h1); drive(1'b1, 4'hD);
        drive(1'b0, 4'h0);
        @(negedge clk); #1;
        check(out_en === 1'b0, "R3", {7'b0, out_en}, 8'h00);
        idle(2);
        // then with a 0x5 before it: a real delimiter, empty payload
        preamble(1);
        drive(1'b0, 4'h0);
        expect_fcs(32'h00000000, "R3");

        // R8: new burst inside the FCS is discarded
        cur_req = "R8";
        preamble(2);
        send_byte(8'h41);
        drive(1'b0, 4'h0);
        for (int i = 0; i < 12; i++) drive(1'b1, 4'h5);
        @(negedge clk); #1;
        check(out_en === 1'b0, "R8", {7'b0, out_en}, 8'h00);
        idle(3);

        // R2 / R6: back-to-back frame accepted right after an FCS
        cur_req = "R6";
        preamble(4);
        send_byte(8'h00); send_byte(8'hFF);
        drive(1'b0, 4'h0);
        idle(7);
        preamble(2);
        send_byte(8'h5A);
        drive(1'b0, 4'h0);
        idle(10);

        // R2 / R4 / R5 / R7: random frames and gaps
        cur_req = "R4";
        for (int f = 0; f < 40; f++) begin
            int plen = $urandom_range(0, 40);
            preamble($urandom_range(1, 15));
            for (int i = 0; i < plen; i++) send_byte(8'($urandom));
            drive(1'b0, 4'h0);
            idle($urandom_range(0, 12));
        end
        idle(12);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1000000;
        miscompares++;
        $display("FAIL watchdog: run did not complete, expected completion");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule